// File: doc/BRIEF.md
# Address/Data Bus Demultiplexer

This block splits a time-shared byte-wide port into a full external address and a separate data view. The low address byte and the data byte travel over the same eight lines at different times. A high-going address strobe marks the address phase. While the strobe is high, the low address is passed through and captured. Once the strobe drops, the captured byte keeps driving the low half of the external address bus. The shared lines are then free to carry data for the rest of the access.

The upper address byte arrives on its own dedicated port and is placed directly above the held low byte. The data view shows the shared lines only outside the address phase. Capture is synchronous: the hold register loads the shared lines on every rising clock edge at which the strobe is high. During the strobe-high phase the output is transparent, so the external address follows the shared lines within the same cycle.

Top module: `addr_data_demux`

## Requirements
- R1: An active-low asynchronous reset clears the held low address byte to 0x00, so after reset with the strobe low ext_addr[7:0] reads 0x00.
- R2: While addr_stb is 1, ext_addr[7:0] equals shared_bus combinationally, in the same cycle.
- R3: At every rising clock edge where addr_stb is 1, the held low byte loads shared_bus. After the strobe falls, ext_addr[7:0] shows the value sampled at the last such edge.
- R4: While addr_stb is 0, ext_addr[7:0] does not follow shared_bus; it shows the held byte.
- R5: ext_addr[15:8] equals addr_hi at all times, independent of the strobe.
- R6: data_view equals shared_bus while addr_stb is 0, and reads 0x00 while addr_stb is 1.
- R7: The held low byte changes only at clock edges where addr_stb was 1, or through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shared_bus | input | 8 | Time-shared low address / data lines |
| addr_stb | input | 1 | Address strobe, high during the address phase |
| addr_hi | input | 8 | Upper address byte from its dedicated port |
| ext_addr | output | 16 | Recovered external address {addr_hi, held low byte} |
| data_view | output | 8 | Data phase view of the shared lines |

## Verification
The hardest case is the cycle in which the strobe falls while the shared lines already carry a different value. In that cycle the held byte must match the value sampled at the last strobe-high edge, not anything driven later. The stimulus therefore changes shared_bus on the same cycle the strobe drops, in both directed and random sequences. It also uses single-cycle and multi-cycle strobe pulses, and applies a reset in the middle of a run. A behavioural model compares both outputs on every cycle.

// File: rtl/addr_data_demux.sv
module addr_data_demux #(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int AW = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LO_W-1:0] shared_bus,
  input  logic            addr_stb,
  input  logic [HI_W-1:0] addr_hi,
  output logic [AW-1:0]   ext_addr,
  output logic [LO_W-1:0] data_view
);

  logic [LO_W-1:0] lo_q;
  logic            past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (addr_stb) lo_q <= shared_bus;
    end
  end

  assign ext_addr  = {addr_hi, (addr_stb ? shared_bus : lo_q)};
  assign data_view = addr_stb ? '0 : shared_bus;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !past_ok |-> lo_q == '0 || $past(addr_stb));

  // R3
  strobe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(addr_stb) |-> lo_q == $past(shared_bus));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !addr_stb && !$past(addr_stb) |-> $stable(ext_addr[LO_W-1:0]));

  // R7
  no_spurious_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(addr_stb) |-> $stable(lo_q));

endmodule

// File: tb/addr_data_demux_tb.sv
module addr_data_demux_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] shared_bus = '0;
  logic       addr_stb = 1'b0;
  logic [7:0] addr_hi = '0;
  logic [15:0] ext_addr;
  logic [7:0]  data_view;

  int checks = 0;
  int fails  = 0;
  int model_lo = 0;
  bit prev_stb = 0;

  always #2.5 clk = ~clk;

  addr_data_demux dut_i (
    .clk(clk), .rst_n(rst_n), .shared_bus(shared_bus), .addr_stb(addr_stb),
    .addr_hi(addr_hi), .ext_addr(ext_addr), .data_view(data_view)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int bus, input bit stb, input int hi);
    @(negedge clk);
    shared_bus = bus[7:0];
    addr_stb   = stb;
    addr_hi    = hi[7:0];
    #1;
    check("R5", int'(ext_addr[15:8]), hi & 8'hff);
    if (stb) begin
      check("R2", int'(ext_addr[7:0]), bus & 8'hff);
      check("R6", int'(data_view), 0);
    end else begin
      check(prev_stb ? "R3" : "R4/R7", int'(ext_addr[7:0]), model_lo);
      check("R6", int'(data_view), bus & 8'hff);
    end
    if (stb) model_lo = bus & 8'hff;
    prev_stb = stb;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    addr_stb = 1'b0;
    model_lo = 0;
    prev_stb = 0;
    #1;
    check("R1", int'(ext_addr[7:0]), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    step(8'h5a, 0, 8'h12);
    // R1: after reset, held byte still zero
    step(8'hc3, 0, 8'h34);
    // single-cycle strobe, bus changes as strobe falls (R3)
    step(8'h81, 1, 8'h40);
    step(8'h7e, 0, 8'h40);
    step(8'h00, 0, 8'h40);
    step(8'hff, 0, 8'h41);
    // multi-cycle strobe, last sampled value wins (R3)
    step(8'h11, 1, 8'h90);
    step(8'h22, 1, 8'h90);
    step(8'h33, 1, 8'h90);
    step(8'hee, 0, 8'h90);
    step(8'hdd, 0, 8'h91);
    // mid-run reset clears held byte (R1)
    do_reset();
    step(8'hab, 0, 8'haa);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      step(r & 8'hff, ((r >> 8) & 3) == 0, (r >> 16) & 8'hff);
    end
    do_reset();
    step(8'h01, 0, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule